// File: doc/BRIEF.md
# Framed Parallel-to-Serial Transmitter

This block turns a stream of parallel data words into a serial bit stream that carries its own clock. One clock drives it, running at the serial bit rate. A bit counter inside divides that clock by the frame length, so a word strobe fires once per frame. On each strobe the block captures the parallel input word. It then sends the word one frame later, wrapped between a high start bit and a low stop bit. Each frame therefore holds `DATA_W + 2` bits, and the payload rate is `DATA_W` bits per word period.

After reset, the serial output stays disabled while the far-end receiver's clock recovery settles. The output-enable flag is low during this time and the line is driven low. The wait is a fixed number of word strobes. When it ends, the block sends a set number of frames whose data bits are all zero, so the receiver can acquire frame lock. It then sends captured words back to back, with no idle gaps. The force-idle input, or a reset, returns the block to the disabled state and restarts the whole sequence.

Top module: `fser_tx`

## Requirements
- R1: `word_strobe` is high for exactly one cycle in every `DATA_W+2` cycles. It is high in the first cycle after reset is released.
- R2: A frame is sent in this order: a start bit of 1, data bit 0 through data bit `DATA_W-1`, then a stop bit of 0. The start bit appears in the cycle after a strobe cycle. The stop bit appears in the strobe cycle, so with the output enabled a frame spans exactly `DATA_W+2` cycles and ends on a strobe.
- R3: The word on `word_in` at the clock edge that samples `word_strobe` high is sent in the frame that starts at the next strobe edge. This holds once the block is in data mode.
- R4: `serial_oe` rises at the clock edge that samples the `LOCK_WORDS`-th high `word_strobe` counted while `force_idle` is low, after reset or after the last cycle in which `force_idle` was high.
- R5: While `serial_oe` is low, `serial_out` and `locked` are both 0.
- R6: The first `RESYNC_FRAMES` frames after `serial_oe` rises carry all-zero data, and `locked` stays low during them. From the next frame on, `locked` is high and frames carry captured words.
- R7: `force_idle` sampled high at an edge makes `serial_oe` and `locked` low after that edge. It also clears the lock count, so the zero frames of R6 are sent again on the next exit.
- R8: `rst` is synchronous and active high. After it, `serial_oe` and `locked` are 0 and the bit counter restarts, as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock, running at `DATA_W+2` times the word rate |
| rst | input | 1 | Synchronous active-high reset |
| force_idle | input | 1 | Sends the block back to the disabled state and restarts the lock wait |
| word_in | input | DATA_W | Parallel word, sampled on the edge where `word_strobe` is high |
| serial_out | output | 1 | Serial data: the framed bit stream, or 0 while disabled |
| serial_oe | output | 1 | Output enable; low stands for the high-impedance line state |
| locked | output | 1 | High while captured words are being sent |
| word_strobe | output | 1 | One-cycle pulse marking the word boundary |

## Verification
A word sampled at a strobe edge is due on the line starting one full frame later. Its start bit appears one cycle after the next strobe edge, and its stop bit appears in the strobe cycle after that. The bench keeps a short history of driven words and, whenever a frame completes, compares the frame against the word that is two strobes old. `serial_oe` and `locked` change only at strobe edges, and `force_idle` takes effect one cycle after it is sampled. The bench samples every output at the falling edge and counts the strobes seen during the disabled phase, so that each check falls in the cycle the registers place the result.

// File: rtl/fser_pkg.sv
package fser_pkg;

  // Link state of the transmitter
  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,   // output disabled, counting lock periods
    ST_RESYNC = 2'd1,   // output enabled, sending zero frames
    ST_DATA   = 2'd2    // output enabled, sending captured words
  } tx_state_e;

  // What the shift register takes on at a word strobe
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,     // quiet line
    LD_ZERO = 2'd1,     // framed all-zero word
    LD_DATA = 2'd2      // framed captured word
  } load_kind_e;

  // Serial bits per frame for a given payload width
  function automatic int unsigned frame_bits(input int unsigned data_w);
    return data_w + 2;
  endfunction

endpackage

// File: rtl/fser_bit_timer.sv
module fser_bit_timer #(
  parameter int unsigned FRAME_LEN = 12
) (
  input  logic clk,
  input  logic rst,
  output logic strobe
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN);

  logic [CNT_W-1:0] bit_idx;

  function automatic logic [CNT_W-1:0] next_idx(input logic [CNT_W-1:0] cur);
    if (cur == CNT_W'(FRAME_LEN - 1)) return '0;
    return cur + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) bit_idx <= '0;
    else     bit_idx <= next_idx(bit_idx);
  end

  assign strobe = (bit_idx == '0);

endmodule

// File: rtl/fser_lock_ctrl.sv
module fser_lock_ctrl
  import fser_pkg::*;
#(
  parameter int unsigned LOCK_WORDS    = 2049,
  parameter int unsigned RESYNC_FRAMES = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       force_idle,
  input  logic       strobe,
  output tx_state_e  state,
  output load_kind_e load_kind
);
  localparam int unsigned WAIT_W = $clog2(LOCK_WORDS + 1);
  localparam int unsigned RS_W   = $clog2(RESYNC_FRAMES + 1);

  logic [WAIT_W-1:0] wait_cnt, wait_nxt;
  logic [RS_W-1:0]   rs_cnt, rs_nxt;
  tx_state_e         state_nxt;

  always_comb begin
    state_nxt = state;
    load_kind = LD_NONE;
    wait_nxt  = wait_cnt;
    rs_nxt    = rs_cnt;
    if (strobe) begin
      unique case (state)
        ST_WAIT: begin
          if (wait_cnt == WAIT_W'(LOCK_WORDS - 1)) begin
            state_nxt = ST_RESYNC;
            load_kind = LD_ZERO;
            wait_nxt  = '0;
            rs_nxt    = RS_W'(1);
          end else begin
            wait_nxt = wait_cnt + WAIT_W'(1);
          end
        end
        ST_RESYNC: begin
          if (rs_cnt >= RS_W'(RESYNC_FRAMES)) begin
            state_nxt = ST_DATA;
            load_kind = LD_DATA;
          end else begin
            load_kind = LD_ZERO;
            rs_nxt    = rs_cnt + RS_W'(1);
          end
        end
        ST_DATA:  load_kind = LD_DATA;
        default:  state_nxt = ST_WAIT;
      endcase
    end
    if (force_idle) begin
      state_nxt = ST_WAIT;
      load_kind = LD_NONE;
      wait_nxt  = '0;
      rs_nxt    = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_WAIT;
      wait_cnt <= '0;
      rs_cnt   <= '0;
    end else begin
      state    <= state_nxt;
      wait_cnt <= wait_nxt;
      rs_cnt   <= rs_nxt;
    end
  end

endmodule

// File: rtl/fser_shifter.sv
module fser_shifter
  import fser_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              strobe,
  input  load_kind_e        load_kind,
  input  logic [DATA_W-1:0] word_in,
  output logic              serial_bit
);
  localparam int unsigned FRAME_LEN = frame_bits(DATA_W);

  logic [DATA_W-1:0]    in_reg;
  logic [FRAME_LEN-1:0] sreg;

  // LSB leaves first: start (1), data LSB first, stop (0)
  function automatic logic [FRAME_LEN-1:0] pack_frame(input logic [DATA_W-1:0] d);
    return {1'b0, d, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)         in_reg <= '0;
    else if (strobe) in_reg <= word_in;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sreg <= '0;
    end else if (strobe) begin
      unique case (load_kind)
        LD_ZERO: sreg <= pack_frame('0);
        LD_DATA: sreg <= pack_frame(in_reg);
        default: sreg <= '0;
      endcase
    end else begin
      sreg <= {1'b0, sreg[FRAME_LEN-1:1]};
    end
  end

  assign serial_bit = sreg[0];

endmodule

// File: rtl/fser_tx.sv
module fser_tx
  import fser_pkg::*;
#(
  parameter int unsigned DATA_W        = 10,
  parameter int unsigned LOCK_WORDS    = 2049,
  parameter int unsigned RESYNC_FRAMES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              force_idle,
  input  logic [DATA_W-1:0] word_in,
  output logic              serial_out,
  output logic              serial_oe,
  output logic              locked,
  output logic              word_strobe
);
  localparam int unsigned FRAME_LEN = frame_bits(DATA_W);

  logic       strobe;
  tx_state_e  state;
  load_kind_e load_kind;

  fser_bit_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  fser_lock_ctrl #(
    .LOCK_WORDS    (LOCK_WORDS),
    .RESYNC_FRAMES (RESYNC_FRAMES)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .force_idle (force_idle),
    .strobe     (strobe),
    .state      (state),
    .load_kind  (load_kind)
  );

  fser_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .clear      (force_idle),
    .strobe     (strobe),
    .load_kind  (load_kind),
    .word_in    (word_in),
    .serial_bit (serial_out)
  );

  assign word_strobe = strobe;
  assign serial_oe   = (state != ST_WAIT);
  assign locked      = (state == ST_DATA);

endmodule

// File: rtl/fser_tx_chk.sv
module fser_tx_chk #(
  parameter int unsigned FRAME_LEN = 12
) (
  input logic clk,
  input logic rst,
  input logic force_idle,
  input logic word_strobe,
  input logic serial_out,
  input logic serial_oe,
  input logic locked
);
  localparam int unsigned GAP_W = $clog2(FRAME_LEN);

  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)              gap <= GAP_W'(FRAME_LEN - 1);
    else if (word_strobe) gap <= '0;
    else                  gap <= gap + GAP_W'(1);
  end

  // R1
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    word_strobe |-> gap == GAP_W'(FRAME_LEN - 1));

  // R1
  strobe_due_chk: assert property (@(posedge clk) disable iff (rst)
    gap == GAP_W'(FRAME_LEN - 1) |-> word_strobe);

  // R2
  stop_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (serial_oe && word_strobe) |-> !serial_out);

  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(word_strobe) && serial_oe) |-> serial_out);

  // R4
  oe_rise_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(serial_oe) |-> $past(word_strobe));

  // R5
  quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
    !serial_oe |-> (!serial_out && !locked));

  // R6
  locked_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(word_strobe) && $past(serial_oe)));

  // R7
  force_idle_chk: assert property (@(posedge clk) disable iff (rst)
    force_idle |=> (!serial_oe && !locked));

endmodule

bind fser_tx fser_tx_chk #(.FRAME_LEN(FRAME_LEN)) i_fser_tx_chk (
  .clk         (clk),
  .rst         (rst),
  .force_idle  (force_idle),
  .word_strobe (word_strobe),
  .serial_out  (serial_out),
  .serial_oe   (serial_oe),
  .locked      (locked)
);

// File: tb/test_fser_tx.sv
`timescale 1ns/1ps
module test_fser_tx;
  localparam int DW   = 10;
  localparam int LOCK = 6;
  localparam int RS   = 2;
  localparam int FL   = DW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          force_idle = 1'b0;
  logic [DW-1:0] word_in = '0;
  logic          serial_out, serial_oe, locked, word_strobe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fser_tx #(.DATA_W(DW), .LOCK_WORDS(LOCK), .RESYNC_FRAMES(RS)) i_fser_tx (
    .clk(clk), .rst(rst), .force_idle(force_idle), .word_in(word_in),
    .serial_out(serial_out), .serial_oe(serial_oe), .locked(locked),
    .word_strobe(word_strobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] gen_word(input int s);
    if (s < 1100) return DW'(s % 1024);
    return DW'((s * 389) ^ 'h2B5);
  endfunction

  // Monitor and word driver, all at the falling edge
  int            lock_cnt, nbits, fidx, gap, seq;
  bit            prev_oe, prev_fi, prev_rst, seen;
  logic [FL-1:0] rx;
  logic [DW-1:0] hist[$];

  initial begin
    prev_rst = 1'b1;
    forever begin
      @(negedge clk);
      if (rst) begin
        lock_cnt = 0; nbits = 0; fidx = 0; gap = 0; seen = 0;
        prev_oe = 0; prev_fi = 0; hist.delete();
      end else begin
        if (prev_rst) begin
          // R8 reset state
          check(serial_oe == 0, "R8 oe after reset", serial_oe, 0);
          check(locked == 0, "R8 locked after reset", locked, 0);
          check(word_strobe == 1, "R8 R1 strobe after reset", word_strobe, 1);
        end
        if (prev_fi) begin
          check(serial_oe == 0, "R7 oe after force_idle", serial_oe, 0);
          check(locked == 0, "R7 locked after force_idle", locked, 0);
        end
        if (force_idle) lock_cnt = 0;
        if (word_strobe) begin
          if (seen) check(gap == FL - 1, "R1 strobe spacing", gap + 1, FL);
          gap = 0; seen = 1;
        end else begin
          gap++;
        end
        if (!serial_oe) begin
          check(serial_out == 0 && locked == 0, "R5 quiet line",
                {serial_out, locked}, 0);
          if (word_strobe && !force_idle) lock_cnt++;
        end else begin
          if (!prev_oe) begin
            check(lock_cnt == LOCK, "R4 lock wait strobes", lock_cnt, LOCK);
            check(locked == 0, "R6 locked low on exit", locked, 0);
            nbits = 0; fidx = 0;
          end
          rx = {serial_out, rx[FL-1:1]};
          nbits++;
          if (word_strobe) begin
            logic [DW-1:0] exp_w;
            check(nbits == FL, "R2 frame boundary", nbits, FL);
            check(rx[0] == 1'b1, "R2 start bit", rx[0], 1);
            check(rx[FL-1] == 1'b0, "R2 stop bit", rx[FL-1], 0);
            if (fidx < RS) begin
              exp_w = '0;
              check(rx[DW:1] == exp_w, "R6 zero frame data", rx[DW:1], exp_w);
            end else begin
              exp_w = (hist.size() >= 2) ? hist[hist.size()-2] : '0;
              check(rx[DW:1] == exp_w, "R3 R2 data bits", rx[DW:1], exp_w);
            end
            check(locked == (fidx >= RS), "R6 locked flag", locked, fidx >= RS);
            fidx++;
            nbits = 0;
          end
        end
        if (word_strobe) begin
          word_in = gen_word(seq);
          seq++;
          hist.push_back(word_in);
          if (hist.size() > 6) void'(hist.pop_front());
        end
        prev_oe = serial_oe;
        prev_fi = force_idle;
      end
      prev_rst = rst;
    end
  end

  task automatic run_frames(input int n);
    repeat (n * FL) @(posedge clk);
  endtask

  task automatic pulse_idle(input int cycles);
    @(posedge clk); #1 force_idle = 1'b1;
    repeat (cycles) @(posedge clk);
    #1 force_idle = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    seq = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // Full sweep of all data values after lock (R3, R2)
    run_frames(LOCK + RS + 1024 + 8);
    // R7: single-cycle force_idle mid-frame, then full re-entry
    pulse_idle(1);
    run_frames(LOCK + RS + 10);
    // R7, R4: force_idle again during the lock wait restarts the count
    pulse_idle(1);
    run_frames(3);
    repeat (5) @(posedge clk);
    pulse_idle(7);
    run_frames(LOCK + RS + 10);
    // R8: reset in the middle of data mode
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    run_frames(LOCK + RS + 12);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule